// File: doc/BRIEF.md
# Serial Address Shifter with Post-Increment

This block keeps a write address and sends it, one bit at a time, into two chained serial-in/parallel-out shift registers outside the chip. It drives a data line and a shift clock. A one-cycle `start` pulse begins a load. The block sends the upper byte first, and each byte most significant bit first, so the final bit to arrive sits at bit 0 of the external chain. When the last rising edge of the shift clock has gone out, the internal address steps up by one and `done` pulses. The next load then targets the next location.

Each bit follows the same pattern. The data line changes at the moment the shift clock falls. The clock stays low for `PHASE_CYCLES` system clocks and then high for the same count, so the external register samples on a rising edge that comes well after the data settled. Between loads the shift clock rests high. The address is built from byte-wide slices, and a carry ripples from each slice into the next. All-ones wraps to zero.

Top module: `addr_shifter`

## Requirements
- R1: Whenever reset is active, `addr` is 0, `sclk` is 1 and `done` is 0, including when reset arrives in the middle of a load.
- R2: A `start` pulse while idle produces exactly `BYTE_W*NUM_BYTES` rising edges of `sclk` (16 by default) before `done`.
- R3: The bits presented at the rising edges are `addr[15]` first, down to `addr[0]` last: the upper byte before the lower byte, and each byte from bit 7 to bit 0.
- R4: `sdo` changes only in the cycle in which `sclk` falls. Each low phase of `sclk` lasts exactly `PHASE_CYCLES` clocks, and `sdo` keeps its value through the rising edge.
- R5: `sclk` is 1 whenever no load is in progress.
- R6: `done` is high for exactly one cycle. It rises `PHASE_CYCLES` clocks after the last rising edge of `sclk`, when the final high phase ends.
- R7: `addr` increases by one in the same cycle that `done` is high. The lower byte carries into the upper byte when it goes from 0xFF to 0x00 (for example, 0x00FF becomes 0x0100).
- R8: All-ones wraps to zero (0xFFFF to 0x0000).
- R9: A `start` pulse during a load has no effect: that load still has the standard edge count, no extra load follows it, and `sclk` remains high afterwards.
- R10: `addr` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously inside |
| start | input | 1 | One-cycle request to send the current address |
| sdo | output | 1 | Serial data to the external shift chain |
| sclk | output | 1 | Shift clock; the external chain samples on its rising edge |
| done | output | 1 | One-cycle pulse when a load has completed |
| addr | output | BYTE_W*NUM_BYTES | Address to be sent by the next load |

## Verification
Over several hundred loads the bench checks the carry out of the lower byte at 0x00FF. A design that fails to propagate it would show 0x0000 in place of 0x0100. A second instance with 4-bit slices runs through its full range to confirm the nibble carry and the all-ones wrap. The bench also checks R4: data must be stable for the whole low phase and across the rising edge, and a bit-index error would appear as a bit-reversed or byte-swapped frame in the scoreboard. Finally, it pokes `start` in the middle of a load and applies reset in the middle of a load, to catch restarted frames, extra edges or an address that does not clear.

// File: rtl/ash_pkg.sv
package ash_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } ash_state_e;

  function automatic int unsigned ash_cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ash_rst_sync.sv
module ash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/ash_addr_ctr.sv
module ash_addr_ctr #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc,
  output logic [BYTE_W*NUM_BYTES-1:0]   addr_o
);
  localparam int ADDR_W = BYTE_W * NUM_BYTES;

  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  addr_d;
  logic [NUM_BYTES:0] carry;

  assign carry[0] = 1'b1;

  // byte slices with an explicit ripple carry between them
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slice
    logic [BYTE_W-1:0] cur;
    assign cur = addr_q[b*BYTE_W +: BYTE_W];
    assign addr_d[b*BYTE_W +: BYTE_W] = cur + {{(BYTE_W-1){1'b0}}, carry[b]};
    assign carry[b+1] = carry[b] & (&cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (inc) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ash_seq.sv
module ash_seq
  import ash_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PHASE_CYCLES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           sclk_o,
  output logic                           done_o,
  output logic                           busy_o,
  output logic                           load_o,
  output logic [ash_cnt_w(ADDR_W)-1:0]   load_idx_o,
  output logic                           inc_o
);
  localparam int BIT_W = ash_cnt_w(ADDR_W);
  localparam int PH_W  = ash_cnt_w(PHASE_CYCLES);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(ADDR_W - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASE_CYCLES - 1);

  ash_state_e       st_q, st_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             phase_end;
  logic             run_en;

  assign phase_end = (ph_q == PH_LAST);
  assign run_en    = (st_q == ST_SHIFT) || start || done_q;

  always_comb begin
    st_d       = st_q;
    sclk_d     = sclk_q;
    bit_d      = bit_q;
    ph_d       = ph_q;
    done_d     = 1'b0;
    load_o     = 1'b0;
    load_idx_o = bit_q;
    inc_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        sclk_d = 1'b1;
        if (start) begin
          st_d       = ST_SHIFT;
          sclk_d     = 1'b0;
          bit_d      = '0;
          ph_d       = '0;
          load_o     = 1'b1;
          load_idx_o = '0;
        end
      end
      ST_SHIFT: begin
        if (!phase_end) begin
          ph_d = ph_q + 1'b1;
        end else begin
          ph_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else if (bit_q == LAST_BIT) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            inc_o  = 1'b1;
          end else begin
            bit_d      = bit_q + 1'b1;
            sclk_d     = 1'b0;
            load_o     = 1'b1;
            load_idx_o = bit_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b1;
      done_q <= 1'b0;
      bit_q  <= '0;
      ph_q   <= '0;
    end else if (run_en) begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
    end
  end

  assign sclk_o = sclk_q;
  assign done_o = done_q;
  assign busy_o = (st_q == ST_SHIFT);
endmodule

// File: rtl/ash_ser.sv
module ash_ser
  import ash_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ash_cnt_w(ADDR_W)-1:0]  idx,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          sdo_o
);
  logic [ADDR_W-1:0] send_order;
  logic              sdo_q;

  // position 0 of send_order is the first bit on the wire (address MSB)
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign send_order[i] = addr[ADDR_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sdo_q <= 1'b0;
    else if (load) sdo_q <= send_order[idx];
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/addr_shifter.sv
module addr_shifter
  import ash_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int NUM_BYTES    = 2,
  parameter int PHASE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        sdo,
  output logic                        sclk,
  output logic                        done,
  output logic [BYTE_W*NUM_BYTES-1:0] addr
);
  localparam int ADDR_W = BYTE_W * NUM_BYTES;
  localparam int BIT_W  = ash_cnt_w(ADDR_W);

  logic             rst_sn;
  logic             busy;
  logic             load;
  logic [BIT_W-1:0] load_idx;
  logic             inc;

  ash_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  ash_seq #(.ADDR_W(ADDR_W), .PHASE_CYCLES(PHASE_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start      (start),
    .sclk_o     (sclk),
    .done_o     (done),
    .busy_o     (busy),
    .load_o     (load),
    .load_idx_o (load_idx),
    .inc_o      (inc)
  );

  ash_addr_ctr #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .inc    (inc),
    .addr_o (addr)
  );

  ash_ser #(.ADDR_W(ADDR_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (load),
    .idx   (load_idx),
    .addr  (addr),
    .sdo_o (sdo)
  );
endmodule

// File: rtl/addr_shifter_chk.sv
module addr_shifter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              busy,
  input logic              sdo,
  input logic              sclk,
  input logic              done,
  input logic [ADDR_W-1:0] addr
);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> sclk);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sclk) |-> $stable(sdo));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  assert_done_ends_load_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (!busy && $past(busy)));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !done |-> (addr == $past(addr)));

  assert_post_inc_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

bind addr_shifter addr_shifter_chk #(.ADDR_W(BYTE_W*NUM_BYTES)) u_chk (
  .clk    (clk),
  .rst_sn (rst_sn),
  .busy   (busy),
  .sdo    (sdo),
  .sclk   (sclk),
  .done   (done),
  .addr   (addr)
);

// File: tb/test_addr_shifter.sv
module test_addr_shifter;
  localparam int P = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        start, sdo, sclk, done;
  logic [15:0] addr;
  logic        start_s, sdo_s, sclk_s, done_s;
  logic [7:0]  addr_s;

  addr_shifter #(.BYTE_W(8), .NUM_BYTES(2), .PHASE_CYCLES(P)) i_addr_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo), .sclk(sclk),
    .done(done), .addr(addr)
  );

  addr_shifter #(.BYTE_W(4), .NUM_BYTES(2), .PHASE_CYCLES(1)) i_addr_shifter_small (
    .clk(clk), .rst_n(rst_n), .start(start_s), .sdo(sdo_s), .sclk(sclk_s),
    .done(done_s), .addr(addr_s)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] exp_q[$];
  logic [15:0] model;
  bit          active;

  // monitor / scoreboard
  logic        prev_sclk, prev_sdo, prev_done;
  logic [15:0] prev_addr, shreg, exp_item;
  int          rises, since_rise, low_run;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk  = 1'b1; prev_sdo = 1'b0; prev_done = 1'b0;
      prev_addr  = 16'h0; shreg = 16'h0;
      rises = 0; since_rise = 0; low_run = 0;
    end else begin
      if (sclk && !prev_sclk) begin
        chk(low_run == P, "R4", "low phase length", low_run, P);
        chk(sdo == prev_sdo, "R4", "sdo held into rising edge", sdo, prev_sdo);
        shreg = {shreg[14:0], sdo};
        rises++;
        since_rise = 0;
        low_run = 0;
      end else begin
        since_rise++;
      end
      if (!sclk) low_run++;
      if (!active && !sclk) chk(0, "R5", "sclk low while idle", sclk, 1);
      if (!done && addr != prev_addr) chk(0, "R10", "addr moved without done", addr, prev_addr);
      if (done && prev_done) chk(0, "R6", "done longer than one cycle", 2, 1);
      if (done) begin
        chk(rises == 16, "R2", "rising edges per load", rises, 16);
        chk(since_rise == P, "R6", "done delay after last edge", since_rise, P);
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected extra load", 1, 0);
        end else begin
          exp_item = exp_q.pop_front();
          chk(shreg == exp_item, "R3", "serial word", shreg, exp_item);
          chk(addr == exp_item + 16'd1, "R7", "post-increment", addr, exp_item + 16'd1);
          if (exp_item == 16'h00FF)
            chk(addr == 16'h0100, "R7", "low byte carry", addr, 16'h0100);
        end
        rises = 0;
      end
      prev_sclk = sclk; prev_sdo = sdo; prev_done = done; prev_addr = addr;
    end
  end

  task automatic frame(input bit poke);
    @(negedge clk);
    start = 1'b1;
    active = 1'b1;
    exp_q.push_back(model);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1;            // R9: request during an active load
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    active = 1'b0;
    model = model + 16'd1;
    if (poke) begin
      repeat (6) begin
        @(negedge clk);
        chk(sclk && !done, "R9", "no load after ignored start", {sclk, done}, 2'b10);
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_s = 1'b0; model = 16'h0; active = 1'b0;
    repeat (3) @(negedge clk);
    chk(addr == 16'h0, "R1", "addr in reset", addr, 0);
    chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sclk == 1'b1, "R5", "sclk idle after reset", sclk, 1);

    for (int k = 0; k < 300; k++) frame(k == 5 || k == 260);

    // reset in the middle of a load
    @(negedge clk);
    start = 1'b1; active = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(addr == 16'h0, "R1", "addr after mid-load reset", addr, 0);
    chk(sclk == 1'b1, "R1", "sclk after mid-load reset", sclk, 1);
    chk(done == 1'b0, "R1", "done after mid-load reset", done, 0);
    exp_q.delete();
    model = 16'h0; active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    frame(1'b0);
    frame(1'b0);

    // small instance: full range, nibble carry and wrap
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      start_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0;
      while (!done_s) @(negedge clk);
      if (k == 15)
        chk(addr_s == 8'h10, "R7", "nibble carry", addr_s, 8'h10);
      else if (k == 255)
        chk(addr_s == 8'h00, "R8", "all-ones wrap", addr_s, 8'h00);
      else
        chk(addr_s == 8'(k + 1), "R7", "small post-increment", addr_s, 8'(k + 1));
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all loads completed", exp_q.size(), 0);
    summary();
  end
endmodule